// File: doc/BRIEF.md
# Precise Exception Pipeline Controller

This controller sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It keeps a small record for each instruction in flight: a valid bit, the instruction's PC and a fault code. The record moves one stage down the pipe every clock, alongside the instruction. Each stage can report a fault for the instruction it holds. The fault is written into that instruction's record, but nothing is done about it yet. The machine acts only when the record reaches write-back. Every older instruction has completed by then, and no younger one has changed state, so the exception is precise.

At commit, the controller pulses a redirect that loads the fetch PC with the supplied vector address. It asserts a flush for fetch, decode, execute and memory, and on the next cycle it exposes the faulting PC in an exception-PC register and the fault type in a cause register. An external interrupt is handled in the same way as a fault. The fetched instruction is replaced by a no-op that carries the interrupt cause, and this no-op then travels to write-back and commits like any other fault. While a faulting instruction is in flight, memory and register writes are held off for it and for everything younger.

Control is a two-state machine. In ST_RUN, no faulted record is in flight and an interrupt may be injected. The transition "arm" moves to ST_ARMED as soon as any record gains a fault or an interrupt is injected. In ST_ARMED, the transition "commit" (a faulted record in write-back) flushes the pipe and returns to ST_RUN.

Top module: `exc_precise_ctrl`

## Requirements
- R1: After reset, redirect_o, flush_o, both inhibits, epc_o and cause_o are all zero, and no record is valid.
- R2: A fetch fault is taken only with if_valid_i high. Its bits map to cause codes as follows: bit0 (page fault) gives 1, bit1 (misaligned) gives 2, and bit2 (protection) gives 3. When several bits are set, the lowest set bit decides.
- R3: A decode illegal-opcode fault gives code 4, and an execute arithmetic fault gives code 5. Memory faults map as follows: bit0 (page fault) gives 6, bit1 (misaligned) gives 7, bit2 (protection) gives 8, and bit3 (memory error) gives 9. The lowest set memory bit decides.
- R4: A fault commits in the cycle its instruction is in write-back. That is 4 cycles after a fetch fault, 3 after a decode fault, 2 after an execute fault and 1 after a memory fault. In that cycle redirect_o is 1 and redirect_pc_o equals vector_i.
- R5: From the cycle after a commit, epc_o holds the committed instruction's PC and cause_o holds its code. Both stay unchanged until the next commit.
- R6: In a commit cycle, flush_o is 4'b1111 (bit0 fetch, bit1 decode, bit2 execute, bit3 memory). Every instruction then in flight is discarded with its fault, so two commits never occur in back-to-back cycles.
- R7: An instruction keeps its first fault. A later-stage fault on an instruction that is already faulted does not change its code.
- R8: When several instructions fault, the oldest commits first. The younger ones are flushed and never commit.
- R9: irq_i is taken only in ST_RUN and outside a commit cycle. Taking it sets flush_o[0] and injects a valid no-op with cause 10 and PC equal to if_pc_i. While a fault is pending, no further injection happens.
- R10: mem_wr_inhibit_o is high when the memory-stage instruction carries a fault, whether from this cycle or from earlier, or in a commit cycle. reg_wr_inhibit_o is high exactly in commit cycles.
- R11: Fault inputs for an empty stage, or a fetch fault with if_valid_i low, are ignored and never lead to a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid_i | input | 1 | A real instruction is being fetched |
| if_pc_i | input | PC_W | PC of the fetched instruction |
| if_fault_i | input | 3 | Fetch faults: page, misaligned, protection |
| id_illegal_i | input | 1 | Decode-stage illegal opcode |
| ex_arith_i | input | 1 | Execute-stage arithmetic fault |
| mem_fault_i | input | 4 | Memory faults: page, misaligned, protection, error |
| irq_i | input | 1 | External interrupt request (level) |
| vector_i | input | PC_W | Handler address |
| reg_wr_inhibit_o | output | 1 | Suppress the register-file write in write-back |
| mem_wr_inhibit_o | output | 1 | Suppress the memory-stage store |
| flush_o | output | 4 | Squash fetch/decode/execute/memory |
| redirect_o | output | 1 | Load the fetch PC with redirect_pc_o |
| redirect_pc_o | output | PC_W | Redirect target |
| epc_o | output | PC_W | PC of the last committed fault |
| cause_o | output | 4 | Code of the last committed fault |

## Verification
The assertions check properties that hold on every cycle. In a commit cycle they check the target address, the full flush and both inhibits. They also check that commits occur only from ST_ARMED and never in back-to-back cycles, that the exception registers hold between commits, and that injection happens only from ST_RUN. Other behaviours need an ordered history of instructions, and only the bench scenarios can show them. These are the exact commit latency for each stage, the priority of an older fault over a younger one, and a first fault surviving a later one on the same instruction. The bench scenarios also show that an interrupt no-op commits with the PC it replaced, and that faults on empty slots vanish.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int CAUSE_W = 4;

    typedef enum logic [CAUSE_W-1:0] {
        C_NONE       = 4'd0,
        C_IF_PAGE    = 4'd1,
        C_IF_ALIGN   = 4'd2,
        C_IF_PROT    = 4'd3,
        C_ID_ILLEGAL = 4'd4,
        C_EX_ARITH   = 4'd5,
        C_MEM_PAGE   = 4'd6,
        C_MEM_ALIGN  = 4'd7,
        C_MEM_PROT   = 4'd8,
        C_MEM_ERR    = 4'd9,
        C_IRQ        = 4'd10
    } cause_e;

    typedef enum logic {
        ST_RUN,
        ST_ARMED
    } ctl_state_e;
endpackage

// File: rtl/exc_cause_enc.sv
module exc_cause_enc
    import exc_pkg::*;
#(
    parameter int N    = 1,
    parameter int BASE = 1
) (
    input  logic [N-1:0]         hit_i,
    output logic [CAUSE_W-1:0]   code_o
);
    // lowest set bit wins: scan downward so the last write is the lowest
    always_comb begin
        code_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_i[i]) code_o = CAUSE_W'(BASE + i);
        end
    end
endmodule

// File: rtl/exc_slot.sv
module exc_slot
    import exc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush_i,
    input  logic                 v_i,
    input  logic [PC_W-1:0]      pc_i,
    input  logic [CAUSE_W-1:0]   code_i,
    input  logic [CAUSE_W-1:0]   local_i,
    output logic                 v_o,
    output logic [PC_W-1:0]      pc_o,
    output logic [CAUSE_W-1:0]   code_o
);
    logic                v_q;
    logic [PC_W-1:0]     pc_q;
    logic [CAUSE_W-1:0]  code_q;

    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            v_q    <= 1'b0;
            pc_q   <= '0;
            code_q <= '0;
        end else begin
            v_q    <= v_i;
            pc_q   <= pc_i;
            code_q <= v_i ? code_i : '0;
        end
    end

    // first fault sticks; an empty slot drops its stage's fault
    always_comb begin
        v_o  = v_q;
        pc_o = pc_q;
        if (!v_q)
            code_o = '0;
        else if (code_q == '0)
            code_o = local_i;
        else
            code_o = code_q;
    end
endmodule

// File: rtl/exc_precise_ctrl.sv
module exc_precise_ctrl
    import exc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 if_valid_i,
    input  logic [PC_W-1:0]      if_pc_i,
    input  logic [2:0]           if_fault_i,
    input  logic                 id_illegal_i,
    input  logic                 ex_arith_i,
    input  logic [3:0]           mem_fault_i,
    input  logic                 irq_i,
    input  logic [PC_W-1:0]      vector_i,
    output logic                 reg_wr_inhibit_o,
    output logic                 mem_wr_inhibit_o,
    output logic [3:0]           flush_o,
    output logic                 redirect_o,
    output logic [PC_W-1:0]      redirect_pc_o,
    output logic [PC_W-1:0]      epc_o,
    output logic [CAUSE_W-1:0]   cause_o
);
    localparam int NSLOT  = 4;           // decode, execute, memory, write-back
    localparam int WB_IX  = NSLOT - 1;
    localparam int MEM_IX = NSLOT - 2;

    ctl_state_e state_q, state_d;

    logic [CAUSE_W-1:0] if_code, id_code, ex_code, mem_code;
    logic               commit, inject, arm;

    logic                in_v    [NSLOT];
    logic [PC_W-1:0]     in_pc   [NSLOT];
    logic [CAUSE_W-1:0]  in_code [NSLOT];
    logic [CAUSE_W-1:0]  loc     [NSLOT];
    logic                eff_v   [NSLOT];
    logic [PC_W-1:0]     eff_pc  [NSLOT];
    logic [CAUSE_W-1:0]  eff_code[NSLOT];

    exc_cause_enc #(.N(3), .BASE(1)) u_enc_if  (.hit_i(if_fault_i),   .code_o(if_code));
    exc_cause_enc #(.N(1), .BASE(4)) u_enc_id  (.hit_i(id_illegal_i), .code_o(id_code));
    exc_cause_enc #(.N(1), .BASE(5)) u_enc_ex  (.hit_i(ex_arith_i),   .code_o(ex_code));
    exc_cause_enc #(.N(4), .BASE(6)) u_enc_mem (.hit_i(mem_fault_i),  .code_o(mem_code));

    assign commit = eff_v[WB_IX] && (eff_code[WB_IX] != '0);
    assign inject = irq_i && (state_q == ST_RUN) && !commit;

    // record entering decode, and the hand-off chain between slots
    always_comb begin
        in_v[0]    = !commit && (if_valid_i || inject);
        in_pc[0]   = if_pc_i;
        if (commit)
            in_code[0] = '0;
        else if (inject)
            in_code[0] = C_IRQ;
        else if (if_valid_i)
            in_code[0] = if_code;
        else
            in_code[0] = '0;
        for (int k = 1; k < NSLOT; k++) begin
            in_v[k]    = eff_v[k-1];
            in_pc[k]   = eff_pc[k-1];
            in_code[k] = eff_code[k-1];
        end
        loc[0]     = id_code;
        loc[1]     = ex_code;
        loc[2]     = mem_code;
        loc[WB_IX] = '0;
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        exc_slot #(.PC_W(PC_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush_i (commit),
            .v_i     (in_v[g]),
            .pc_i    (in_pc[g]),
            .code_i  (in_code[g]),
            .local_i (loc[g]),
            .v_o     (eff_v[g]),
            .pc_o    (eff_pc[g]),
            .code_o  (eff_code[g])
        );
    end

    always_comb begin
        arm = (in_v[0] && in_code[0] != '0);
        for (int k = 0; k < WB_IX; k++) begin
            if (eff_code[k] != '0) arm = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (arm)    state_d = ST_ARMED;
            ST_ARMED: if (commit) state_d = ST_RUN;
            default:              state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_o   <= '0;
            cause_o <= '0;
        end else if (commit) begin
            epc_o   <= eff_pc[WB_IX];
            cause_o <= eff_code[WB_IX];
        end
    end

    // outputs
    always_comb begin
        redirect_o       = commit;
        redirect_pc_o    = commit ? vector_i : '0;
        flush_o          = commit ? '1 : {3'b000, inject};
        reg_wr_inhibit_o = commit;
        mem_wr_inhibit_o = commit || (eff_code[MEM_IX] != '0);
    end
endmodule

// File: rtl/exc_precise_ctrl_chk.sv
module exc_precise_ctrl_chk
    import exc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [PC_W-1:0]     vector_i,
    input logic                reg_wr_inhibit_o,
    input logic                mem_wr_inhibit_o,
    input logic [3:0]          flush_o,
    input logic                redirect_o,
    input logic [PC_W-1:0]     redirect_pc_o,
    input logic [PC_W-1:0]     epc_o,
    input logic [CAUSE_W-1:0]  cause_o,
    input ctl_state_e          state_q
);
    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cause_o == '0 && epc_o == '0 && !redirect_o)); // R1
    AST_VECTOR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> redirect_pc_o == vector_i); // R4
    AST_COMMIT_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> state_q == ST_ARMED); // R4
    AST_CAUSE_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> cause_o != '0); // R5
    AST_EXC_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_o |=> ($stable(cause_o) && $stable(epc_o))); // R5
    AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> flush_o == 4'b1111); // R6
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o); // R6
    AST_INHIBIT_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (reg_wr_inhibit_o && mem_wr_inhibit_o)); // R10
    AST_REG_INHIBIT_ONLY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_inhibit_o |-> redirect_o); // R10
    AST_INJECT_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o[0] && !redirect_o) |-> state_q == ST_RUN); // R9
    AST_SINGLE_INJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o[0] && !redirect_o) |=> !(flush_o[0] && !redirect_o)); // R9
endmodule

bind exc_precise_ctrl exc_precise_ctrl_chk #(.PC_W(PC_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .vector_i         (vector_i),
    .reg_wr_inhibit_o (reg_wr_inhibit_o),
    .mem_wr_inhibit_o (mem_wr_inhibit_o),
    .flush_o          (flush_o),
    .redirect_o       (redirect_o),
    .redirect_pc_o    (redirect_pc_o),
    .epc_o            (epc_o),
    .cause_o          (cause_o),
    .state_q          (state_q)
);

// File: tb/sim_exc_precise_ctrl.sv
module sim_exc_precise_ctrl;
    localparam int CLK_P = 10;
    localparam int PC_W  = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            if_valid_i = 1'b0;
    logic [PC_W-1:0] if_pc_i = '0;
    logic [2:0]      if_fault_i = '0;
    logic            id_illegal_i = 1'b0;
    logic            ex_arith_i = 1'b0;
    logic [3:0]      mem_fault_i = '0;
    logic            irq_i = 1'b0;
    logic [PC_W-1:0] vector_i = 32'h8000_0180;
    logic            reg_wr_inhibit_o, mem_wr_inhibit_o, redirect_o;
    logic [3:0]      flush_o;
    logic [PC_W-1:0] redirect_pc_o, epc_o;
    logic [3:0]      cause_o;

    exc_precise_ctrl #(.PC_W(PC_W)) u0 (.*);

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        int              stage;   // 1 decode, 2 execute, 3 memory, 4 write-back
        logic [PC_W-1:0] pc;
        int              code;
    } ent_t;

    ent_t            pipe[$];
    logic [PC_W-1:0] m_epc = '0;
    int              m_cause = 0;
    int              n_chk = 0, n_fail = 0, cyc = 0;
    int              last_redir = -1, redir_cnt = 0;
    logic            obs_mem_inh;
    logic [3:0]      obs_flush;

    function automatic int enc(input logic [3:0] b, input int n, input int base);
        for (int i = 0; i < n; i++) if (b[i]) return base + i;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic tick();
        bit              commit, pending, inject, mem_here;
        logic [PC_W-1:0] wb_pc;
        int              wb_code, mem_eff;
        logic [3:0]      e_flush;
        logic            e_mem_inh;
        ent_t            nq[$];
        @(negedge clk);
        #1;
        cyc++;
        commit = 0; pending = 0; mem_here = 0; wb_pc = '0; wb_code = 0; mem_eff = 0;
        foreach (pipe[i]) begin
            if (pipe[i].code != 0) pending = 1;
            if (pipe[i].stage == 4 && pipe[i].code != 0) begin
                commit = 1; wb_pc = pipe[i].pc; wb_code = pipe[i].code;
            end
            if (pipe[i].stage == 3) begin
                mem_here = 1;
                mem_eff  = (pipe[i].code != 0) ? pipe[i].code : enc(mem_fault_i, 4, 6);
            end
        end
        inject    = irq_i && !commit && !pending;
        e_flush   = commit ? 4'b1111 : {3'b000, inject};
        e_mem_inh = commit || (mem_here && mem_eff != 0);
        chk(redirect_o == commit, "R4 redirect", 64'(redirect_o), 64'(commit));
        chk(redirect_pc_o == (commit ? vector_i : '0), "R4 target", 64'(redirect_pc_o), 64'(commit ? vector_i : '0));
        chk(flush_o == e_flush, "R6/R9 flush", 64'(flush_o), 64'(e_flush));
        chk(epc_o == m_epc && int'(cause_o) == m_cause, "R5 epc/cause",
            {epc_o, 28'd0, cause_o}, {m_epc, 28'd0, 4'(m_cause)});
        chk(mem_wr_inhibit_o == e_mem_inh && reg_wr_inhibit_o == commit, "R10 inhibit",
            {mem_wr_inhibit_o, reg_wr_inhibit_o}, {e_mem_inh, commit});
        obs_mem_inh = mem_wr_inhibit_o;
        obs_flush   = flush_o;
        if (redirect_o) begin
            last_redir = cyc;
            redir_cnt++;
        end
        @(posedge clk);
        if (commit) begin
            m_epc = wb_pc; m_cause = wb_code;
            pipe.delete();
        end else begin
            foreach (pipe[i]) begin
                ent_t e;
                e = pipe[i];
                if (e.code == 0) begin
                    if (e.stage == 1) e.code = enc({3'b0, id_illegal_i}, 1, 4);
                    else if (e.stage == 2) e.code = enc({3'b0, ex_arith_i}, 1, 5);
                    else if (e.stage == 3) e.code = enc(mem_fault_i, 4, 6);
                end
                e.stage++;
                if (e.stage <= 4) nq.push_back(e);
            end
            if (if_valid_i || inject) begin
                ent_t n;
                n.stage = 1; n.pc = if_pc_i;
                n.code  = inject ? 10 : enc({1'b0, if_fault_i}, 3, 1);
                nq.push_back(n);
            end
            pipe = nq;
        end
        #1;
        if_fault_i = '0; id_illegal_i = 1'b0; ex_arith_i = 1'b0; mem_fault_i = '0;
        if_pc_i = if_pc_i + 4;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int              fc;
        logic [PC_W-1:0] fpc;
        if_pc_i = 32'h0000_1000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(!redirect_o && flush_o == 0 && !reg_wr_inhibit_o && !mem_wr_inhibit_o, "R1 outputs",
            {redirect_o, flush_o, reg_wr_inhibit_o, mem_wr_inhibit_o}, 0);
        chk(epc_o == 0 && cause_o == 0, "R1 regs", {epc_o, cause_o}, 0);
        rst_n = 1'b1; if_valid_i = 1'b1;
        idle(6);

        // R2: fetch fault, two bits set, lowest (misaligned) wins
        fc = cyc + 1; fpc = if_pc_i; if_fault_i = 3'b110;
        tick(); idle(6);
        chk(last_redir == fc + 4, "R4 fetch latency", 64'(last_redir), 64'(fc + 4));
        chk(cause_o == 4'd2, "R2 cause", 64'(cause_o), 64'd2);
        chk(epc_o == fpc, "R5 epc", 64'(epc_o), 64'(fpc));

        // R3: decode, execute and memory faults
        fc = cyc + 1; id_illegal_i = 1'b1; tick(); idle(6);
        chk(last_redir == fc + 3, "R4 decode latency", 64'(last_redir), 64'(fc + 3));
        chk(cause_o == 4'd4, "R3 illegal cause", 64'(cause_o), 64'd4);
        fc = cyc + 1; ex_arith_i = 1'b1; tick(); idle(6);
        chk(last_redir == fc + 2, "R4 execute latency", 64'(last_redir), 64'(fc + 2));
        chk(cause_o == 4'd5, "R3 arith cause", 64'(cause_o), 64'd5);
        fc = cyc + 1; mem_fault_i = 4'b1100; tick();
        chk(obs_mem_inh == 1'b1, "R10 store blocked", 64'(obs_mem_inh), 64'd1);
        idle(6);
        chk(last_redir == fc + 1, "R4 memory latency", 64'(last_redir), 64'(fc + 1));
        chk(cause_o == 4'd8, "R3 protection cause", 64'(cause_o), 64'd8);

        // R7: first fault of an instruction survives a later one
        fpc = if_pc_i; if_fault_i = 3'b001; tick(); tick(); tick();
        mem_fault_i = 4'b1000; tick(); idle(5);
        chk(cause_o == 4'd1 && epc_o == fpc, "R7 first fault kept", {epc_o, cause_o}, {fpc, 4'd1});

        // R8: older execute fault beats younger decode fault
        redir_cnt = 0; fc = cyc + 1; ex_arith_i = 1'b1; id_illegal_i = 1'b1;
        tick(); idle(8);
        chk(redir_cnt == 1 && cause_o == 4'd5, "R8 oldest wins", {32'(redir_cnt), cause_o}, {32'd1, 4'd5});

        // R9: interrupt injection, level held until commit
        redir_cnt = 0; fc = cyc + 1; fpc = if_pc_i; irq_i = 1'b1;
        tick();
        chk(obs_flush == 4'b0001, "R9 inject flush", 64'(obs_flush), 64'd1);
        idle(4); irq_i = 1'b0;
        chk(last_redir == fc + 4, "R9 irq latency", 64'(last_redir), 64'(fc + 4));
        chk(redir_cnt == 1 && cause_o == 4'd10 && epc_o == fpc, "R9 irq commit",
            {epc_o, 28'(redir_cnt), cause_o}, {fpc, 28'd1, 4'd10});

        // R11: faults with nothing valid are dropped
        redir_cnt = 0; if_valid_i = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if_fault_i = 3'b111; id_illegal_i = 1'b1; ex_arith_i = 1'b1; mem_fault_i = 4'hF;
            tick();
        end
        idle(2);
        chk(redir_cnt == 0 && cause_o == 4'd10, "R11 ignored", {32'(redir_cnt), cause_o}, {32'd0, 4'd10});

        // mixed random traffic, compared against the model each cycle
        for (int i = 0; i < 400; i++) begin
            if_valid_i   = ($urandom_range(0, 9) != 0);
            if_fault_i   = ($urandom_range(0, 29) == 0) ? 3'($urandom_range(1, 7)) : 3'b0;
            id_illegal_i = ($urandom_range(0, 39) == 0);
            ex_arith_i   = ($urandom_range(0, 39) == 0);
            mem_fault_i  = ($urandom_range(0, 39) == 0) ? 4'($urandom_range(1, 15)) : 4'b0;
            irq_i        = ($urandom_range(0, 24) == 0);
            vector_i     = 32'h8000_0000 | 32'($urandom_range(0, 255) << 2);
            tick();
        end
        irq_i = 1'b0;
        idle(6);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule